// File: doc/BRIEF.md
# Row-Serial Compute-in-Memory Array Sequencer

This block drives a binary-weight compute-in-memory array one row at a time. A start pulse launches a pass. The pass begins at row 0 and walks a one-hot row pointer down to the last row in use. Each row goes through three phases. In the first, the bitlines are equalized and discharged. In the second, one wordline of the selected row is raised together with that row's plate line. The input data bit for that row decides which wordline it is: the true one or the complement one. In the third, the wordline and plate line stay up and the latch-type sense amplifier is enabled.

The length of each phase is set by a cycle count. At the end of every sense phase the block gives a one-cycle result strobe together with the row index, so that a downstream accumulator can capture the sensed column outputs. When the last row has been sensed, the block returns to idle and holds a done flag until the next start. The per-row data bits, the row count and the three phase lengths are captured when the pass starts.

Top module: `rowseq_top`

## Requirements
- R1: While reset is held, and after it is released, the block is idle. All wordlines, plate lines, `eq`, `sap`, `res_valid`, `busy` and `done` are low, and `sap_n` is high.
- R2: A start sampled while idle puts row 0 into its equalize phase in the next cycle. Rows are then visited in ascending index order, one row at a time, and `busy` is high for the whole pass.
- R3: For the active row i during access and sense, `din_vec[i]`=1 raises `wl_true[i]` and `din_vec[i]`=0 raises `wl_comp[i]`. `pl_en[i]` is raised in both cases. No other row's lines and not both wordlines of a row are ever high.
- R4: Each row runs its phases in a fixed order. First `eq` alone, then access (wordline and plate line), then sense (wordline, plate line and `sap`). `eq` is never high in the same cycle as any wordline, plate line or `sap`.
- R5: `sap_n` is the exact complement of `sap` in every cycle.
- R6: Each phase lasts exactly as many cycles as its length input (`eq_len`, `acc_len`, `sns_len`) gives. A length of 0 is treated as 1.
- R7: `res_valid` is high for exactly one cycle per row, in the last cycle of that row's sense phase, and `res_row` then carries the row index.
- R8: A pass covers rows 0 to N-1, where N is `row_count`. A `row_count` of 0, or one larger than ROWS, selects all ROWS rows.
- R9: The cycle after the last row's final sense cycle, the block is idle with `done` high. `done` stays high until the next start is sampled.
- R10: While a pass is running, `start` and any change to `din_vec`, `row_count` or the phase lengths have no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a pass when sampled while idle |
| din_vec | input | ROWS | Input data bit for each row (1 selects the true wordline) |
| row_count | input | $clog2(ROWS+1) | Number of rows in the pass (0 or over ROWS means all) |
| eq_len | input | LEN_W | Equalize phase length in cycles |
| acc_len | input | LEN_W | Access phase length in cycles |
| sns_len | input | LEN_W | Sense phase length in cycles |
| wl_true | output | ROWS | True wordline per row |
| wl_comp | output | ROWS | Complement wordline per row |
| pl_en | output | ROWS | Plate line enable per row |
| eq | output | 1 | Bitline equalize and discharge |
| sap | output | 1 | Sense amplifier enable, active high |
| sap_n | output | 1 | Sense amplifier enable, active low |
| res_valid | output | 1 | Row result strobe |
| res_row | output | $clog2(ROWS) | Index of the row whose result is strobed |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass has completed |

## Verification
A start sampled at clock edge k makes row 0's equalize phase visible in the cycle after edge k. From then on, each row takes exactly E+A+S cycles after the effective lengths are applied. The strobe lands in cycle E+A+S of each row, and the idle state with `done` high follows one cycle after the last strobe. The bench drives inputs on the falling edge and builds the full expected trace from the requirements, cycle by cycle. It compares every output on each falling edge of the pass and of the idle cycles after it, so an early or late phase edge shows up in the exact cycle it occurs.

// File: rtl/rowseq_pkg.sv
// Package rowseq_pkg
// Holds the phase encoding shared by the sequencer modules.
// Assumes nothing beyond a single clock domain.
package rowseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EQ   = 2'd1,
        PH_ACC  = 2'd2,
        PH_SNS  = 2'd3
    } phase_t;

endpackage

// File: rtl/rowseq_phase_timer.sv
// Module rowseq_phase_timer
// Down-counter that times the current phase. A load gives the length of
// the phase that starts next cycle. A length of 0 is treated as 1.
// Assumes load is pulsed only in the cycle before a new phase begins.
module rowseq_phase_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             last
);

    logic [LEN_W-1:0] cnt_q;

    // Counter: reload on a phase change, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? '0 : len - LEN_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    // Final cycle of the running phase
    always_comb begin
        last = (cnt_q == '0);
    end

endmodule

// File: rtl/rowseq_row_ptr.sv
// Module rowseq_row_ptr
// One-hot row pointer with a matching binary index. A clear returns it to
// row 0 and an advance moves it one row toward the bottom.
// Assumes the controller never advances past the last row in use.
module rowseq_row_ptr #(
    parameter int ROWS  = 8,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [ROWS-1:0]  row_oh,
    output logic [ROW_W-1:0] row_idx
);

    logic [ROWS-1:0]  oh_q;
    logic [ROW_W-1:0] idx_q;

    // Pointer update: clear to the top row, or step down one row
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            oh_q  <= ROWS'(1);
            idx_q <= '0;
        end else if (advance) begin
            oh_q  <= {oh_q[ROWS-2:0], oh_q[ROWS-1]};
            idx_q <= idx_q + ROW_W'(1);
        end
    end

    // Drive the outputs
    always_comb begin
        row_oh  = oh_q;
        row_idx = idx_q;
    end

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oh_q)) else $error("pointer not one-hot"); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (idx_q == $past(idx_q) + ROW_W'(1))) else $error("pointer step wrong"); // R2

endmodule

// File: rtl/rowseq_wl_drv.sv
// Module rowseq_wl_drv
// Splits each row select into a true or complement wordline based on that
// row's data bit, and drives the row's plate line alongside either one.
// Assumes row_oh is one-hot and that active marks the access and sense phases.
module rowseq_wl_drv #(
    parameter int ROWS = 8
) (
    input  logic            active,
    input  logic [ROWS-1:0] row_oh,
    input  logic [ROWS-1:0] din,
    output logic [ROWS-1:0] wl_true,
    output logic [ROWS-1:0] wl_comp,
    output logic [ROWS-1:0] pl_en
);

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        // Per-row select split by the input bit
        always_comb begin
            pl_en[g]   = active & row_oh[g];
            wl_true[g] = active & row_oh[g] &  din[g];
            wl_comp[g] = active & row_oh[g] & ~din[g];
        end
    end

endmodule

// File: rtl/rowseq_top.sv
// Module rowseq_top
// Row-serial sequencer for a compute-in-memory array. For each row in turn
// it runs equalize, then access (wordline plus plate line), then sense,
// each phase for a set number of cycles. It strobes a result at the end of
// every sense phase and flags done after the last row.
// Assumes ROWS >= 2. Settings are captured when a start is accepted.
module rowseq_top #(
    parameter int ROWS  = 8,
    parameter int LEN_W = 4,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CNT_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROWS-1:0]  din_vec,
    input  logic [CNT_W-1:0] row_count,
    input  logic [LEN_W-1:0] eq_len,
    input  logic [LEN_W-1:0] acc_len,
    input  logic [LEN_W-1:0] sns_len,
    output logic [ROWS-1:0]  wl_true,
    output logic [ROWS-1:0]  wl_comp,
    output logic [ROWS-1:0]  pl_en,
    output logic             eq,
    output logic             sap,
    output logic             sap_n,
    output logic             res_valid,
    output logic [ROW_W-1:0] res_row,
    output logic             busy,
    output logic             done
);
    import rowseq_pkg::*;

    phase_t           ph_q, ph_d;
    logic [ROWS-1:0]  din_q;
    logic [ROW_W-1:0] last_row_q;
    logic [LEN_W-1:0] eq_len_q, acc_len_q, sns_len_q;
    logic             done_q;
    logic             accept;
    logic             t_load, t_last;
    logic [LEN_W-1:0] t_len;
    logic             ptr_adv;
    logic             row_end, pass_end;
    logic [ROWS-1:0]  row_oh;
    logic [ROW_W-1:0] row_idx;
    logic [ROW_W-1:0] last_row_d;

    // Start acceptance: only while idle
    always_comb begin
        accept = (ph_q == PH_IDLE) && start;
    end

    // Clamp the requested row count to the array size
    always_comb begin
        if (row_count == '0 || row_count > CNT_W'(ROWS)) begin
            last_row_d = ROW_W'(ROWS - 1);
        end else begin
            last_row_d = ROW_W'(row_count - CNT_W'(1));
        end
    end

    // Capture pass settings when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q      <= '0;
            last_row_q <= '0;
            eq_len_q   <= '0;
            acc_len_q  <= '0;
            sns_len_q  <= '0;
        end else if (accept) begin
            din_q      <= din_vec;
            last_row_q <= last_row_d;
            eq_len_q   <= eq_len;
            acc_len_q  <= acc_len;
            sns_len_q  <= sns_len;
        end
    end

    // End-of-row and end-of-pass conditions
    always_comb begin
        row_end  = (ph_q == PH_SNS) && t_last;
        pass_end = row_end && (row_idx == last_row_q);
    end

    // Phase sequencing and timer load selection
    always_comb begin
        ph_d    = ph_q;
        t_load  = 1'b0;
        t_len   = eq_len_q;
        ptr_adv = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_d   = PH_EQ;
                    t_load = 1'b1;
                    t_len  = eq_len;
                end
            end
            PH_EQ: begin
                if (t_last) begin
                    ph_d   = PH_ACC;
                    t_load = 1'b1;
                    t_len  = acc_len_q;
                end
            end
            PH_ACC: begin
                if (t_last) begin
                    ph_d   = PH_SNS;
                    t_load = 1'b1;
                    t_len  = sns_len_q;
                end
            end
            PH_SNS: begin
                if (pass_end) begin
                    ph_d = PH_IDLE;
                end else if (t_last) begin
                    ph_d    = PH_EQ;
                    t_load  = 1'b1;
                    t_len   = eq_len_q;
                    ptr_adv = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Done flag: set at pass end, cleared by the next accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (accept) begin
            done_q <= 1'b0;
        end else if (pass_end) begin
            done_q <= 1'b1;
        end
    end

    rowseq_phase_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .len   (t_len),
        .last  (t_last)
    );

    rowseq_row_ptr #(
        .ROWS  (ROWS),
        .ROW_W (ROW_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (ptr_adv),
        .row_oh  (row_oh),
        .row_idx (row_idx)
    );

    rowseq_wl_drv #(
        .ROWS (ROWS)
    ) u_wl (
        .active  ((ph_q == PH_ACC) || (ph_q == PH_SNS)),
        .row_oh  (row_oh),
        .din     (din_q),
        .wl_true (wl_true),
        .wl_comp (wl_comp),
        .pl_en   (pl_en)
    );

    // Phase-decoded control outputs
    always_comb begin
        eq        = (ph_q == PH_EQ);
        sap       = (ph_q == PH_SNS);
        sap_n     = ~sap;
        res_valid = row_end;
        res_row   = row_idx;
        busy      = (ph_q != PH_IDLE);
        done      = done_q;
    end

    AST_EQ_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        eq |-> ((wl_true | wl_comp | pl_en) == '0) && !sap) else $error("eq overlaps access"); // R4
    AST_ACCESS_AFTER_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|pl_en) |-> $past(eq)) else $error("access without equalize"); // R4
    AST_SENSE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sap) |-> $past(|pl_en)) else $error("sense without access"); // R4
    AST_WL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wl_true | wl_comp) && ((wl_true & wl_comp) == '0)) else $error("wordline not one-hot"); // R3
    AST_VALID_IN_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (sap && busy)) else $error("strobe outside sense"); // R7
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid) else $error("strobe longer than one cycle"); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(res_valid)) else $error("done without final strobe"); // R9

endmodule

// File: tb/rowseq_top_bench.sv
module rowseq_top_bench;
    localparam int ROWS  = 8;
    localparam int LEN_W = 4;
    localparam int ROW_W = $clog2(ROWS);
    localparam int CNT_W = $clog2(ROWS + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [ROWS-1:0]  din_vec = '0;
    logic [CNT_W-1:0] row_count = '0;
    logic [LEN_W-1:0] eq_len = '0, acc_len = '0, sns_len = '0;
    logic [ROWS-1:0]  wl_true, wl_comp, pl_en;
    logic             eq, sap, sap_n, res_valid, busy, done;
    logic [ROW_W-1:0] res_row;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rowseq_top #(.ROWS(ROWS), .LEN_W(LEN_W)) u_rowseq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .din_vec(din_vec),
        .row_count(row_count), .eq_len(eq_len), .acc_len(acc_len),
        .sns_len(sns_len), .wl_true(wl_true), .wl_comp(wl_comp),
        .pl_en(pl_en), .eq(eq), .sap(sap), .sap_n(sap_n),
        .res_valid(res_valid), .res_row(res_row), .busy(busy), .done(done)
    );

    // Compare every output against one expected cycle
    task automatic check_cycle(string tag, logic e_eq, logic e_sap,
                               logic [ROWS-1:0] e_wt, logic [ROWS-1:0] e_wc,
                               logic [ROWS-1:0] e_pl, logic e_v, logic [ROW_W-1:0] e_row,
                               logic e_busy, logic e_done);
        logic [3*ROWS+6+ROW_W-1:0] act, exp;
        act = {eq, sap, sap_n, wl_true, wl_comp, pl_en, res_valid, busy, done,
               e_v ? res_row : e_row};
        exp = {e_eq, e_sap, ~e_sap, e_wt, e_wc, e_pl, e_v, e_busy, e_done, e_row};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Runs one pass and checks every cycle of it plus two idle cycles after
    task automatic run_pass(string tag, logic [ROWS-1:0] din, logic [CNT_W-1:0] rc,
                            logic [LEN_W-1:0] e, logic [LEN_W-1:0] a,
                            logic [LEN_W-1:0] s, bit poke);
        int ne, na, ns, nr;
        ne = (e == 0) ? 1 : int'(e);
        na = (a == 0) ? 1 : int'(a);
        ns = (s == 0) ? 1 : int'(s);
        nr = (rc == 0 || int'(rc) > ROWS) ? ROWS : int'(rc);
        @(negedge clk);
        din_vec = din; row_count = rc; eq_len = e; acc_len = a; sns_len = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: hold start high and scramble every setting during the pass
            start = 1'b1; din_vec = ~din; row_count = 1; eq_len = 7; acc_len = 0; sns_len = 5;
        end
        for (int r = 0; r < nr; r++) begin
            logic [ROWS-1:0] sel, wt, wc;
            sel = ROWS'(1) << r;
            wt  = din[r] ? sel : '0;
            wc  = din[r] ? '0 : sel;
            for (int c = 0; c < ne; c++) begin
                check_cycle({tag, " R4 R2 equalize"}, 1, 0, '0, '0, '0, 0, '0, 1, 0);
                @(negedge clk);
            end
            for (int c = 0; c < na; c++) begin
                check_cycle({tag, " R3 R6 access"}, 0, 0, wt, wc, sel, 0, '0, 1, 0);
                @(negedge clk);
            end
            for (int c = 0; c < ns; c++) begin
                bit lastc;
                lastc = (c == ns - 1);
                check_cycle({tag, " R7 R5 sense"}, 0, 1, wt, wc, sel, lastc,
                            lastc ? ROW_W'(r) : '0, 1, 0);
                if (lastc && r == nr - 1) start = 1'b0;
                @(negedge clk);
            end
        end
        for (int c = 0; c < 2; c++) begin
            check_cycle({tag, " R9 R8 idle done"}, 0, 0, '0, '0, '0, 0, '0, 0, 1);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_cycle("R1 in reset", 0, 0, '0, '0, '0, 0, '0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_cycle("R1 after reset", 0, 0, '0, '0, '0, 0, '0, 0, 0);
    endtask

    task automatic t_basic();      // R2 R3 R4 R5 R7 R9
        run_pass("basic all rows unit phases", 8'hA5, 4'd8, 4'd1, 4'd1, 4'd1, 0);
    endtask

    task automatic t_lengths();    // R6 R8
        run_pass("R6 long phases three rows", 8'h3C, 4'd3, 4'd2, 4'd3, 4'd4, 0);
    endtask

    task automatic t_zero();       // R6 R8: zero lengths act as one, zero count means all
        run_pass("R6 R8 zero settings", 8'h0F, 4'd0, 4'd0, 4'd0, 4'd0, 0);
    endtask

    task automatic t_over();       // R8: count above ROWS means all rows
        run_pass("R8 count over size", 8'hFF, 4'd13, 4'd1, 4'd2, 4'd1, 0);
    endtask

    task automatic t_single();     // R8: single row
        run_pass("R8 single row", 8'h00, 4'd1, 4'd3, 4'd1, 4'd2, 0);
    endtask

    task automatic t_busy();       // R10: start and settings ignored while busy
        run_pass("R10 ignored during pass", 8'h96, 4'd4, 4'd2, 4'd1, 4'd2, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_lengths();
        t_zero();
        t_over();
        t_single();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule